// File: doc/BRIEF.md
# JTAG Probe Shift Engine

This block is the probe side of a JTAG link. A host hands it one transfer at a time: a bit count, one vector of TMS values, one vector of TDI values, a TCK divider value and a capture-mode bit, then pulses a start strobe. The engine produces TCK from the system clock, presents one TMS/TDI pair per TCK period, and collects one TDO sample per period into a result vector. When the transfer is over it raises a one-cycle done pulse and drops its busy flag.

Every change on TMS and TDI lands on a falling TCK edge, or at the start edge while TCK is still low, so the target, which samples on the rising edge, always sees half a TCK period of setup and half of hold. Margin is bought by raising the divider. TDO is normally taken at the rising edge. A late mode takes it on the following falling edge instead. That gives the target a whole period, less its output delay, to present the bit, so a faster TCK can be used.

Top module: `jtag_shift_engine`

## Requirements
- R1: While reset is high and after it is released, tck_o=0, tms_o=1, tdi_o=1, busy_o=0, done_o=0 and tdo_vec_o=0.
- R2: A start_i seen with busy_o low is accepted at that clock edge. From the next cycle busy_o=1, tms_o/tdi_o carry bit 0 of tms_vec_i/tdi_vec_i, tck_o stays 0 and tdo_vec_o reads 0.
- R3: With divider value N (div_i, sampled only at the accepted start), TCK is low for N+1 system clocks after the start edge, then alternates high and low with exactly N+1 clocks in each half. The period is 2(N+1).
- R4: tms_o and tdi_o change only at the start edge or at a falling TCK edge. Bit i (i=0 is the LSB of each vector) is held for the whole TCK period that contains the i-th rising edge.
- R5: len_i holds the bit count minus one (0 means 1 bit, 63 means 64 bits). The transfer runs exactly that many TCK periods.
- R6: With late_i=0 at the start, TDO for bit i is sampled at the system-clock edge where TCK rises for bit i, and it is stored in tdo_vec_o bit i from that edge on.
- R7: With late_i=1 at the start, TDO for bit i is sampled at the falling TCK edge that follows the rise of bit i. This is the edge that launches bit i+1, or the closing fall for the last bit.
- R8: After the closing falling edge of the last bit, done_o is 1 for exactly one cycle, busy_o is 0 in that same cycle, and TCK is low.
- R9: After the last bit, tms_o keeps the last bit's TMS value and tdi_o returns to 1 until the next accepted start.
- R10: A start_i while busy_o is high is ignored, and changes on div_i, len_i, late_i and the vectors during a transfer have no effect.
- R11: TCK is low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle |
| div_i | input | 8 | TCK divider N, half period N+1 clocks |
| len_i | input | 6 | Bit count minus one |
| late_i | input | 1 | 1: capture TDO on the falling edge |
| tms_vec_i | input | 64 | TMS value per bit, LSB first |
| tdi_vec_i | input | 64 | TDI value per bit, LSB first |
| tdo_i | input | 1 | TDO from the target |
| tck_o | output | 1 | Test clock to the target |
| tms_o | output | 1 | Test mode select to the target |
| tdi_o | output | 1 | Test data to the target |
| tdo_vec_o | output | 64 | Captured TDO bits, bit i from period i |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A half-period counter off by one shows up on tck_o within the first N+2 clocks of a transfer, and it shifts every later edge. A wrong bit index or shift register shows up on tms_o or tdi_o at the first falling edge, and the error persists, since each mismatched bit stays on the pins for a full period. A capture aimed at the wrong edge, or at the wrong bit, shows up in tdo_vec_o in the cycle after that sample. The TDO stimulus changes every system clock, so sampling one clock early or late is caught at once. A faulty end-of-transfer count shows up as done_o, busy_o or the idle TDI level being wrong within one TCK period of the expected end.

// File: rtl/jse_pkg.sv
package jse_pkg;

    localparam int MAX_BITS = 64;
    localparam int IDX_W    = $clog2(MAX_BITS);
    localparam int DIV_W    = 8;

    typedef logic [MAX_BITS-1:0] vec_t;
    typedef logic [IDX_W-1:0]    idx_t;
    typedef logic [DIV_W-1:0]    div_t;

    // TCK transition scheduled for the current system-clock edge
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edge_e;

    // Pin pair launched together towards the target
    typedef struct packed {
        logic tms;
        logic tdi;
    } pins_t;

    // Values latched at an accepted start
    typedef struct packed {
        idx_t last;
        logic late;
    } xfer_cfg_t;

    localparam pins_t PINS_RESET = '{tms: 1'b1, tdi: 1'b1};

    function automatic vec_t put_bit(vec_t v, idx_t i, logic b);
        vec_t r;
        r    = v;
        r[i] = b;
        return r;
    endfunction

endpackage

// File: rtl/jse_clkgen.sv
module jse_clkgen
    import jse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  logic  run_i,
    input  div_t  div_i,
    output logic  tck_o,
    output edge_e evt_o
);

    div_t div_q;
    div_t cnt_q;

    always_comb begin
        if (run_i && (cnt_q == div_q))
            evt_o = tck_o ? EV_FALL : EV_RISE;
        else
            evt_o = EV_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
            tck_o <= 1'b0;
        end else if (load_i) begin
            div_q <= div_i;
            cnt_q <= '0;
            tck_o <= 1'b0;
        end else if (evt_o != EV_NONE) begin
            cnt_q <= '0;
            tck_o <= ~tck_o;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/jse_ctrl.sv
module jse_ctrl
    import jse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  idx_t  last_i,
    input  logic  late_i,
    input  edge_e evt_i,
    output logic  load_o,
    output logic  busy_o,
    output logic  done_o,
    output logic  cap_o,
    output idx_t  idx_o,
    output logic  last_bit_o
);

    xfer_cfg_t cfg_q;
    logic      fall;

    assign load_o     = start_i && !busy_o;
    assign fall       = (evt_i == EV_FALL);
    assign last_bit_o = (idx_o == cfg_q.last);
    assign cap_o      = cfg_q.late ? fall : (evt_i == EV_RISE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                cfg_q  <= '{last: last_i, late: late_i};
                busy_o <= 1'b1;
                idx_o  <= '0;
            end else if (fall) begin
                if (last_bit_o) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/jse_launch.sv
module jse_launch
    import jse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  edge_e evt_i,
    input  logic  last_bit_i,
    input  vec_t  tms_vec_i,
    input  vec_t  tdi_vec_i,
    output logic  tms_o,
    output logic  tdi_o
);

    pins_t pins_q;
    vec_t  sr_tms_q;
    vec_t  sr_tdi_q;

    assign tms_o = pins_q.tms;
    assign tdi_o = pins_q.tdi;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q   <= PINS_RESET;
            sr_tms_q <= '0;
            sr_tdi_q <= '0;
        end else if (load_i) begin
            pins_q   <= '{tms: tms_vec_i[0], tdi: tdi_vec_i[0]};
            sr_tms_q <= tms_vec_i >> 1;
            sr_tdi_q <= tdi_vec_i >> 1;
        end else if (evt_i == EV_FALL) begin
            if (last_bit_i) begin
                pins_q.tdi <= 1'b1;
            end else begin
                pins_q   <= '{tms: sr_tms_q[0], tdi: sr_tdi_q[0]};
                sr_tms_q <= sr_tms_q >> 1;
                sr_tdi_q <= sr_tdi_q >> 1;
            end
        end
    end

endmodule

// File: rtl/jse_capture.sv
module jse_capture
    import jse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic cap_i,
    input  idx_t idx_i,
    input  logic tdo_i,
    output vec_t vec_o
);

    always_ff @(posedge clk) begin
        if (rst)
            vec_o <= '0;
        else if (load_i)
            vec_o <= '0;
        else if (cap_i)
            vec_o <= put_bit(vec_o, idx_i, tdo_i);
    end

endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
    import jse_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [IDX_W-1:0]    len_i,
    input  logic                late_i,
    input  logic [MAX_BITS-1:0] tms_vec_i,
    input  logic [MAX_BITS-1:0] tdi_vec_i,
    input  logic                tdo_i,
    output logic                tck_o,
    output logic                tms_o,
    output logic                tdi_o,
    output logic [MAX_BITS-1:0] tdo_vec_o,
    output logic                busy_o,
    output logic                done_o
);

    logic  load;
    logic  cap;
    logic  last_bit;
    idx_t  idx;
    edge_e evt;

    jse_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .last_i     (len_i),
        .late_i     (late_i),
        .evt_i      (evt),
        .load_o     (load),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .cap_o      (cap),
        .idx_o      (idx),
        .last_bit_o (last_bit)
    );

    jse_clkgen u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .run_i  (busy_o),
        .div_i  (div_i),
        .tck_o  (tck_o),
        .evt_o  (evt)
    );

    jse_launch u_launch (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .evt_i      (evt),
        .last_bit_i (last_bit),
        .tms_vec_i  (tms_vec_i),
        .tdi_vec_i  (tdi_vec_i),
        .tms_o      (tms_o),
        .tdi_o      (tdi_o)
    );

    jse_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .cap_i  (cap),
        .idx_i  (idx),
        .tdo_i  (tdo_i),
        .vec_o  (tdo_vec_o)
    );

endmodule

// File: rtl/jse_checker.sv
module jse_checker
    import jse_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [DIV_W-1:0] div_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             tck_o,
    input logic             tms_o,
    input logic             tdi_o
);

    logic [DIV_W:0] div_q;
    logic [DIV_W:0] hcnt_q;
    logic           tck_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= '0;
            hcnt_q     <= '0;
            tck_prev_q <= 1'b0;
        end else begin
            tck_prev_q <= tck_o;
            if (start_i && !busy_o) begin
                div_q  <= {1'b0, div_i};
                hcnt_q <= '0;
            end else if (tck_o != tck_prev_q) begin
                hcnt_q <= 1;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    // R3: each TCK level lasts exactly N+1 system clocks
    assert_half_period_R3: assert property (@(posedge clk) disable iff (rst)
        (tck_o != $past(tck_o)) |-> (hcnt_q == div_q + 1'b1));

    // R4: TMS moves only at a falling TCK edge or at the start edge
    assert_tms_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (tms_o != $past(tms_o)) |-> ($fell(tck_o) || $past(start_i && !busy_o)));

    // R4: TDI moves only at a falling TCK edge or at the start edge
    assert_tdi_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (tdi_o != $past(tdi_o)) |-> ($fell(tck_o) || $past(start_i && !busy_o)));

    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: done coincides with the end of busy
    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R11: TCK idles low
    assert_idle_tck_low_R11: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !tck_o);

endmodule

bind jtag_shift_engine jse_checker u_jse_checker (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .div_i   (div_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .tck_o   (tck_o),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o)
);

// File: tb/jtag_shift_engine_tb_top.sv
module jtag_shift_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  div_i;
    logic [5:0]  len_i;
    logic        late_i;
    logic [63:0] tms_vec_i;
    logic [63:0] tdi_vec_i;
    logic        tdo_i;
    logic        tck_o;
    logic        tms_o;
    logic        tdi_o;
    logic [63:0] tdo_vec_o;
    logic        busy_o;
    logic        done_o;

    int          vectors = 0;
    int          miscompares = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        hist [0:1023];
    logic        idle_tms = 1'b1;
    logic [63:0] idle_vec = '0;

    always #2.5 clk = ~clk;

    jtag_shift_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .div_i     (div_i),
        .len_i     (len_i),
        .late_i    (late_i),
        .tms_vec_i (tms_vec_i),
        .tdi_vec_i (tdi_vec_i),
        .tdo_i     (tdo_i),
        .tck_o     (tck_o),
        .tms_o     (tms_o),
        .tdi_o     (tdi_o),
        .tdo_vec_o (tdo_vec_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(string req, logic edone);
        chk(req, "tck", {63'd0, tck_o}, 64'd0);
        chk(req, "tms", {63'd0, tms_o}, {63'd0, idle_tms});
        chk(req, "tdi", {63'd0, tdi_o}, 64'd1);
        chk(req, "busy", {63'd0, busy_o}, 64'd0);
        chk(req, "done", {63'd0, done_o}, {63'd0, edone});
        chk(req, "tdo_vec", tdo_vec_o, idle_vec);
    endtask

    task automatic drive_tdo(int k);
        tdo_i = lfsr[0];
        if (k >= 0) hist[k] = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // One transfer: n = divider, l = bit count, inj = interval of an extra start (-1 none)
    task automatic run(int n, int l, logic late, logic [63:0] tmsv, logic [63:0] tdiv, int inj);
        int h;
        int tot;
        logic [63:0] evec;
        h   = n + 1;
        tot = 2 * h * l;
        @(negedge clk);
        chk_idle("R11 R9", 1'b0);
        div_i     = 8'(n);
        len_i     = 6'(l - 1);
        late_i    = late;
        tms_vec_i = tmsv;
        tdi_vec_i = tdiv;
        start_i   = 1'b1;
        drive_tdo(-1);
        for (int k = 0; k <= tot + 1; k++) begin
            @(negedge clk);
            evec = '0;
            for (int i = 0; i < l; i++) begin
                int e;
                e = late ? 2 * h * (i + 1) : 2 * h * i + h;
                if (e <= k) evec[i] = hist[e-1];
            end
            if (k < tot) begin
                int b;
                b = k / (2 * h);
                chk("R3", "tck", {63'd0, tck_o}, {63'd0, ((k % (2 * h)) >= h)});
                chk("R4 R2", "tms", {63'd0, tms_o}, {63'd0, tmsv[b]});
                chk("R4 R2", "tdi", {63'd0, tdi_o}, {63'd0, tdiv[b]});
                chk("R2 R10", "busy", {63'd0, busy_o}, 64'd1);
                chk("R8", "done", {63'd0, done_o}, 64'd0);
            end else begin
                chk("R8 R11", "tck", {63'd0, tck_o}, 64'd0);
                chk("R9", "tms", {63'd0, tms_o}, {63'd0, tmsv[l-1]});
                chk("R9", "tdi", {63'd0, tdi_o}, 64'd1);
                chk("R8", "busy", {63'd0, busy_o}, 64'd0);
                chk("R8 R5", "done", {63'd0, done_o}, {63'd0, (k == tot)});
            end
            chk(late ? "R7 R5" : "R6 R5", "tdo_vec", tdo_vec_o, evec);
            if (k == 0) begin
                // R10: inputs changed after the start must have no effect
                start_i   = 1'b0;
                div_i     = 8'(n + 5);
                len_i     = ~6'(l - 1);
                late_i    = ~late;
                tms_vec_i = ~tmsv;
                tdi_vec_i = ~tdiv;
            end
            if (k == inj)     start_i = 1'b1;   // R10: ignored while busy
            if (k == inj + 1) start_i = 1'b0;
            if (k == tot)     start_i = 1'b0;
            drive_tdo(k);
            idle_vec = evec;
        end
        idle_tms = tmsv[l-1];
    endtask

    initial begin
        rst       = 1'b1;
        start_i   = 1'b0;
        div_i     = '0;
        len_i     = '0;
        late_i    = 1'b0;
        tms_vec_i = '0;
        tdi_vec_i = '0;
        tdo_i     = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R1", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1", 1'b0);

        run(0, 1, 1'b0, 64'h1, 64'h0, -1);                                   // R5 one bit
        run(0, 64, 1'b1, 64'hF0E1_D2C3_B4A5_9687, 64'h1234_5678_9ABC_DEF0, -1); // R5 full length, R7
        run(1, 8, 1'b0, 64'h5A, 64'hC3, -1);                                 // R6
        run(2, 5, 1'b1, 64'h16, 64'h09, 7);                                  // R7 R10
        run(3, 33, 1'b0, 64'h1_8000_0001, 64'h0_7FFF_FFFE, 20);              // R3 R10
        run(1, 64, 1'b0, 64'hFFFF_0000_AAAA_5555, 64'h0F0F_F0F0_3C3C_C3C3, -1);
        run(0, 3, 1'b1, 64'h2, 64'h5, 0);                                    // R10 start on next edge
        run(0, 2, 1'b0, 64'h3, 64'h1, 3);                                    // R10 start at closing edge

        @(negedge clk);
        chk_idle("R9 R11", 1'b0);
        summary();
        $finish;
    end

endmodule